// File: doc/BRIEF.md
# Burst-to-Single-Beat Memory Bus Bridge

This block sits between a bus master that issues AXI4 bursts and a slave that accepts only single-beat AXI4-Lite transfers. Every accepted burst address request is replayed as one Lite address per beat. The beat addresses start at the burst address and step by the transfer size. Write data beats travel through untouched. On the return path the responses are framed again for the burst side. For writes, all Lite responses except the final one are absorbed, so the master sees one write response per burst. For reads, every Lite beat is forwarded, tagged with the burst ID and marked last on its final beat.

Each direction keeps a small queue of (ID, length) records, one per accepted burst. The queue depth sets how many bursts may be outstanding at once. When the queue is full, the address input stops accepting. Reads and writes are handled by independent paths, and no ordering is enforced between them. The burst side has no last-beat input on write data: beat counting comes entirely from the address side.

Top module: `burst2lite_bridge`

## Requirements
- R1: A burst request with length field L and size field S produces exactly L+1 Lite addresses in order. The first address equals the burst address, and each later one adds 2^S bytes.
- R2: While a Lite address is valid and not accepted, the address and its valid stay unchanged on the next cycle.
- R3: Each direction holds at most MAX_OVERLAP outstanding bursts. With that many recorded and not yet answered, the burst address ready is low. It returns high in the cycle after a burst's response completes.
- R4: Write data is a combinational pass-through: Lite write valid, data and strobe equal the burst-side values, and burst-side write ready equals Lite write ready.
- R5: For a write burst of L+1 beats, the first L Lite write responses are accepted with no burst-side response. Exactly one burst-side response, carrying the burst ID, is presented with the final Lite response.
- R6: The burst write response code is the final Lite response code. An error code on an earlier beat (SLVERR = 2, OKAY = 0) is not reported.
- R7: Each Lite read beat is forwarded with its data and code and the burst ID. The last flag is high only on beat number L, counting from 0.
- R8: Responses of overlapping bursts carry IDs in the order the bursts were accepted.
- R9: After reset, all outgoing valids are low, and both burst address readies are high.
- R10: A burst-side response that is valid and not accepted keeps its valid and ID, and the matching Lite response is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_aw_valid | input | 1 | Burst write address valid |
| s_aw_ready | output | 1 | Burst write address ready |
| s_aw_id | input | ID_W | Burst write ID |
| s_aw_addr | input | ADDR_W | Burst write start address |
| s_aw_len | input | 8 | Beats minus one |
| s_aw_size | input | 3 | Log2 of bytes per beat |
| s_w_valid | input | 1 | Write data valid |
| s_w_ready | output | 1 | Write data ready |
| s_w_data | input | DATA_W | Write data |
| s_w_strb | input | DATA_W/8 | Write byte strobes |
| s_b_valid | output | 1 | Burst write response valid |
| s_b_ready | input | 1 | Burst write response ready |
| s_b_id | output | ID_W | Burst write response ID |
| s_b_resp | output | 2 | Burst write response code |
| s_ar_valid | input | 1 | Burst read address valid |
| s_ar_ready | output | 1 | Burst read address ready |
| s_ar_id | input | ID_W | Burst read ID |
| s_ar_addr | input | ADDR_W | Burst read start address |
| s_ar_len | input | 8 | Beats minus one |
| s_ar_size | input | 3 | Log2 of bytes per beat |
| s_r_valid | output | 1 | Read data valid |
| s_r_ready | input | 1 | Read data ready |
| s_r_id | output | ID_W | Read data ID |
| s_r_data | output | DATA_W | Read data |
| s_r_resp | output | 2 | Read response code |
| s_r_last | output | 1 | Final beat of the burst |
| m_aw_valid | output | 1 | Lite write address valid |
| m_aw_ready | input | 1 | Lite write address ready |
| m_aw_addr | output | ADDR_W | Lite write address |
| m_w_valid | output | 1 | Lite write data valid |
| m_w_ready | input | 1 | Lite write data ready |
| m_w_data | output | DATA_W | Lite write data |
| m_w_strb | output | DATA_W/8 | Lite write strobes |
| m_b_valid | input | 1 | Lite write response valid |
| m_b_ready | output | 1 | Lite write response ready |
| m_b_resp | input | 2 | Lite write response code |
| m_ar_valid | output | 1 | Lite read address valid |
| m_ar_ready | input | 1 | Lite read address ready |
| m_ar_addr | output | ADDR_W | Lite read address |
| m_r_valid | input | 1 | Lite read data valid |
| m_r_ready | output | 1 | Lite read data ready |
| m_r_data | input | DATA_W | Lite read data |
| m_r_resp | input | 2 | Lite read response code |

## Verification
Several results are combinational: write data, response valid, ID, code and last flag all follow their inputs in the same cycle. The bench checks them one nanosecond after driving inputs at a falling edge. The first Lite address of a burst appears one cycle after the burst address handshake, and each later address appears one cycle after the previous one is accepted. Address ready recovers one cycle after the response that freed a queue entry. Each of these results is checked at the falling edge following the rising edge that updates the register, never at the active edge itself.

// File: rtl/b2l_pkg.sv
package b2l_pkg;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
  localparam int RESP_W = 2;

  typedef enum logic [RESP_W-1:0] {
    RSP_OKAY   = 2'd0,
    RSP_EXOKAY = 2'd1,
    RSP_SLVERR = 2'd2,
    RSP_DECERR = 2'd3
  } resp_e;
endpackage

// File: rtl/b2l_track_fifo.sv
module b2l_track_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign head     = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    if (pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  // R3: the splitter never records a burst into a full tracker
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));
  // R8: the framer only retires a burst that was recorded
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/b2l_splitter.sv
module b2l_splitter
  import b2l_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              track_full,
  output logic              track_push,
  output logic [ID_W+LEN_W-1:0] track_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              accept, beat_done;

  assign in_ready   = !busy_q && !track_full;
  assign accept     = in_valid && in_ready;
  assign track_push = accept;
  assign track_data = {in_id, in_len};
  assign out_valid  = busy_q;
  assign out_addr   = addr_q;
  assign beat_done  = busy_q && out_ready;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    left_d = left_q;
    size_d = size_q;
    if (accept) begin
      busy_d = 1'b1;
      addr_d = in_addr;
      left_d = in_len;
      size_d = in_size;
    end else if (beat_done) begin
      if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        addr_d = addr_q + (ADDR_W'(1) << size_q);
        left_d = left_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      size_q <= '0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      left_q <= left_d;
      size_q <= size_d;
    end
  end

  // R2: a stalled Lite address is held
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
  // R1: first Lite address is the burst start address
  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)));
endmodule

// File: rtl/b2l_resp_framer.sv
module b2l_resp_framer
  import b2l_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int PAY_W       = 2,
  parameter bit FORWARD_ALL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  input  logic             head_valid,
  input  logic [ID_W+LEN_W-1:0] head,
  output logic             pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic [PAY_W-1:0] out_pay,
  output logic             out_last
);
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [LEN_W-1:0] head_len;
  logic             at_last, xfer;

  assign head_len = head[LEN_W-1:0];
  assign out_id   = head[ID_W+LEN_W-1:LEN_W];
  assign out_pay  = in_pay;
  assign at_last  = (beat_q == head_len);
  assign out_last = at_last;

  generate
    if (FORWARD_ALL) begin : g_every_beat
      assign out_valid = in_valid && head_valid;
      assign in_ready  = out_ready && head_valid;
    end else begin : g_final_only
      assign out_valid = in_valid && head_valid && at_last;
      assign in_ready  = head_valid && (!at_last || out_ready);
    end
  endgenerate

  assign xfer = in_valid && in_ready;
  assign pop  = xfer && at_last;

  always_comb begin
    beat_d = beat_q;
    if (xfer) beat_d = at_last ? '0 : beat_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  // R10: a stalled burst-side response keeps valid and ID
  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));
  // R10: the Lite response is not consumed while the burst side stalls
  a_r10_no_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/burst2lite_bridge.sv
module burst2lite_bridge
  import b2l_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int ID_W        = 4,
  parameter int MAX_OVERLAP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_aw_valid,
  output logic                s_aw_ready,
  input  logic [ID_W-1:0]     s_aw_id,
  input  logic [ADDR_W-1:0]   s_aw_addr,
  input  logic [7:0]          s_aw_len,
  input  logic [2:0]          s_aw_size,
  input  logic                s_w_valid,
  output logic                s_w_ready,
  input  logic [DATA_W-1:0]   s_w_data,
  input  logic [DATA_W/8-1:0] s_w_strb,
  output logic                s_b_valid,
  input  logic                s_b_ready,
  output logic [ID_W-1:0]     s_b_id,
  output logic [1:0]          s_b_resp,
  input  logic                s_ar_valid,
  output logic                s_ar_ready,
  input  logic [ID_W-1:0]     s_ar_id,
  input  logic [ADDR_W-1:0]   s_ar_addr,
  input  logic [7:0]          s_ar_len,
  input  logic [2:0]          s_ar_size,
  output logic                s_r_valid,
  input  logic                s_r_ready,
  output logic [ID_W-1:0]     s_r_id,
  output logic [DATA_W-1:0]   s_r_data,
  output logic [1:0]          s_r_resp,
  output logic                s_r_last,
  output logic                m_aw_valid,
  input  logic                m_aw_ready,
  output logic [ADDR_W-1:0]   m_aw_addr,
  output logic                m_w_valid,
  input  logic                m_w_ready,
  output logic [DATA_W-1:0]   m_w_data,
  output logic [DATA_W/8-1:0] m_w_strb,
  input  logic                m_b_valid,
  output logic                m_b_ready,
  input  logic [1:0]          m_b_resp,
  output logic                m_ar_valid,
  input  logic                m_ar_ready,
  output logic [ADDR_W-1:0]   m_ar_addr,
  input  logic                m_r_valid,
  output logic                m_r_ready,
  input  logic [DATA_W-1:0]   m_r_data,
  input  logic [1:0]          m_r_resp
);
  localparam int TRK_W = ID_W + LEN_W;
  localparam int RPAY  = DATA_W + RESP_W;

  logic             wr_push, wr_pop, wr_full, wr_nonempty;
  logic [TRK_W-1:0] wr_rec, wr_head;
  logic             rd_push, rd_pop, rd_full, rd_nonempty;
  logic [TRK_W-1:0] rd_rec, rd_head;
  logic             b_last;
  logic [RPAY-1:0]  r_pay;

  // write data goes straight across
  assign m_w_valid = s_w_valid;
  assign s_w_ready = m_w_ready;
  assign m_w_data  = s_w_data;
  assign m_w_strb  = s_w_strb;

  b2l_splitter #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_wr_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_aw_valid), .in_ready(s_aw_ready), .in_id(s_aw_id),
    .in_addr(s_aw_addr), .in_len(s_aw_len), .in_size(s_aw_size),
    .track_full(wr_full), .track_push(wr_push), .track_data(wr_rec),
    .out_valid(m_aw_valid), .out_ready(m_aw_ready), .out_addr(m_aw_addr));

  b2l_track_fifo #(.WIDTH(TRK_W), .DEPTH(MAX_OVERLAP)) u_wr_track (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_data(wr_rec),
    .pop(wr_pop), .head(wr_head), .full(wr_full), .nonempty(wr_nonempty));

  b2l_resp_framer #(.ID_W(ID_W), .PAY_W(RESP_W), .FORWARD_ALL(1'b0)) u_wr_resp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(m_b_valid), .in_ready(m_b_ready), .in_pay(m_b_resp),
    .head_valid(wr_nonempty), .head(wr_head), .pop(wr_pop),
    .out_valid(s_b_valid), .out_ready(s_b_ready), .out_id(s_b_id),
    .out_pay(s_b_resp), .out_last(b_last));

  b2l_splitter #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_rd_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_ar_valid), .in_ready(s_ar_ready), .in_id(s_ar_id),
    .in_addr(s_ar_addr), .in_len(s_ar_len), .in_size(s_ar_size),
    .track_full(rd_full), .track_push(rd_push), .track_data(rd_rec),
    .out_valid(m_ar_valid), .out_ready(m_ar_ready), .out_addr(m_ar_addr));

  b2l_track_fifo #(.WIDTH(TRK_W), .DEPTH(MAX_OVERLAP)) u_rd_track (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_data(rd_rec),
    .pop(rd_pop), .head(rd_head), .full(rd_full), .nonempty(rd_nonempty));

  b2l_resp_framer #(.ID_W(ID_W), .PAY_W(RPAY), .FORWARD_ALL(1'b1)) u_rd_resp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(m_r_valid), .in_ready(m_r_ready), .in_pay({m_r_data, m_r_resp}),
    .head_valid(rd_nonempty), .head(rd_head), .pop(rd_pop),
    .out_valid(s_r_valid), .out_ready(s_r_ready), .out_id(s_r_id),
    .out_pay(r_pay), .out_last(s_r_last));

  assign s_r_data = r_pay[RPAY-1:RESP_W];
  assign s_r_resp = r_pay[RESP_W-1:0];

  // R5: a burst write response only appears on the final Lite response
  a_r5_b_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    s_b_valid |-> (b_last && m_b_valid));
  // R7: every forwarded read beat comes from a Lite beat
  a_r7_r_from_lite: assert property (@(posedge clk) disable iff (!rst_n)
    s_r_valid |-> m_r_valid);
endmodule

// File: tb/burst2lite_bridge_bench.sv
`timescale 1ns/1ps
module burst2lite_bridge_bench;
  localparam int AW = 32, DW = 32, IW = 4, DEP = 2;

  logic clk = 1'b0, rst_n;
  logic s_aw_valid, s_aw_ready; logic [IW-1:0] s_aw_id; logic [AW-1:0] s_aw_addr;
  logic [7:0] s_aw_len; logic [2:0] s_aw_size;
  logic s_w_valid, s_w_ready; logic [DW-1:0] s_w_data; logic [DW/8-1:0] s_w_strb;
  logic s_b_valid, s_b_ready; logic [IW-1:0] s_b_id; logic [1:0] s_b_resp;
  logic s_ar_valid, s_ar_ready; logic [IW-1:0] s_ar_id; logic [AW-1:0] s_ar_addr;
  logic [7:0] s_ar_len; logic [2:0] s_ar_size;
  logic s_r_valid, s_r_ready, s_r_last; logic [IW-1:0] s_r_id; logic [DW-1:0] s_r_data;
  logic [1:0] s_r_resp;
  logic m_aw_valid, m_aw_ready; logic [AW-1:0] m_aw_addr;
  logic m_w_valid, m_w_ready; logic [DW-1:0] m_w_data; logic [DW/8-1:0] m_w_strb;
  logic m_b_valid, m_b_ready; logic [1:0] m_b_resp;
  logic m_ar_valid, m_ar_ready; logic [AW-1:0] m_ar_addr;
  logic m_r_valid, m_r_ready; logic [DW-1:0] m_r_data; logic [1:0] m_r_resp;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst2lite_bridge #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .MAX_OVERLAP(DEP)) u_burst2lite_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_id(s_aw_id),
    .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len), .s_aw_size(s_aw_size),
    .s_w_valid(s_w_valid), .s_w_ready(s_w_ready), .s_w_data(s_w_data), .s_w_strb(s_w_strb),
    .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id), .s_b_resp(s_b_resp),
    .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_id(s_ar_id),
    .s_ar_addr(s_ar_addr), .s_ar_len(s_ar_len), .s_ar_size(s_ar_size),
    .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id), .s_r_data(s_r_data),
    .s_r_resp(s_r_resp), .s_r_last(s_r_last),
    .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr),
    .m_w_valid(m_w_valid), .m_w_ready(m_w_ready), .m_w_data(m_w_data), .m_w_strb(m_w_strb),
    .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_resp(m_b_resp),
    .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr),
    .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_data(m_r_data), .m_r_resp(m_r_resp));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    s_aw_valid = 0; s_aw_id = '0; s_aw_addr = '0; s_aw_len = '0; s_aw_size = '0;
    s_w_valid = 0; s_w_data = '0; s_w_strb = '0; s_b_ready = 0;
    s_ar_valid = 0; s_ar_id = '0; s_ar_addr = '0; s_ar_len = '0; s_ar_size = '0;
    s_r_ready = 0; m_aw_ready = 0; m_w_ready = 0; m_b_valid = 0; m_b_resp = '0;
    m_ar_ready = 0; m_r_valid = 0; m_r_data = '0; m_r_resp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 m_aw_valid", m_aw_valid, 0);
    chk("R9 m_ar_valid", m_ar_valid, 0);
    chk("R9 s_b_valid", s_b_valid, 0);
    chk("R9 s_r_valid", s_r_valid, 0);
    chk("R9 s_aw_ready", s_aw_ready, 1);
    chk("R9 s_ar_ready", s_ar_ready, 1);
  endtask

  // write burst id 5, 4 beats of 4 bytes, error on a middle beat
  task automatic t_write_burst();
    @(negedge clk);
    s_aw_valid = 1; s_aw_id = 4'd5; s_aw_addr = 32'h100; s_aw_len = 8'd3; s_aw_size = 3'd2;
    #1 chk("R9 aw ready idle", s_aw_ready, 1);
    @(negedge clk);
    s_aw_valid = 0;
    #1 chk("R1 first valid", m_aw_valid, 1);
    chk("R1 first addr", m_aw_addr, 32'h100);
    @(negedge clk);
    #1 chk("R2 held valid", m_aw_valid, 1);
    chk("R2 held addr", m_aw_addr, 32'h100);
    for (int i = 0; i < 4; i++) begin
      m_aw_ready = 1;
      #1 chk("R1 beat addr", m_aw_addr, 64'(32'h100 + 4 * i));
      chk("R1 beat valid", m_aw_valid, 1);
      @(negedge clk);
    end
    m_aw_ready = 0;
    #1 chk("R1 no extra beat", m_aw_valid, 0);
    // R4 write data pass-through
    s_w_valid = 1; s_w_data = 32'hA5A5_0001; s_w_strb = 4'h6; m_w_ready = 0;
    #1 chk("R4 w valid", m_w_valid, 1);
    chk("R4 w data", m_w_data, 32'hA5A5_0001);
    chk("R4 w strb", m_w_strb, 4'h6);
    chk("R4 w ready low", s_w_ready, 0);
    m_w_ready = 1;
    #1 chk("R4 w ready high", s_w_ready, 1);
    @(negedge clk);
    s_w_valid = 0; m_w_ready = 0;
    // intermediate responses absorbed
    s_b_ready = 1;
    for (int i = 0; i < 3; i++) begin
      m_b_valid = 1; m_b_resp = (i == 1) ? 2'd2 : 2'd0;
      #1 chk("R5 no early b", s_b_valid, 0);
      chk("R5 lite b taken", m_b_ready, 1);
      @(negedge clk);
    end
    m_b_resp = 2'd0; s_b_ready = 0;
    #1 chk("R5 b valid", s_b_valid, 1);
    chk("R5 b id", s_b_id, 5);
    chk("R6 b resp last beat", s_b_resp, 0);
    chk("R10 lite b held", m_b_ready, 0);
    @(negedge clk);
    #1 chk("R10 b still valid", s_b_valid, 1);
    chk("R10 b id stable", s_b_id, 5);
    s_b_ready = 1;
    @(negedge clk);
    m_b_valid = 0; s_b_ready = 0;
    #1 chk("R5 single b", s_b_valid, 0);
  endtask

  // read burst id 3, 3 beats of 8 bytes
  task automatic t_read_burst();
    @(negedge clk);
    s_ar_valid = 1; s_ar_id = 4'd3; s_ar_addr = 32'h40; s_ar_len = 8'd2; s_ar_size = 3'd3;
    @(negedge clk);
    s_ar_valid = 0;
    for (int i = 0; i < 3; i++) begin
      m_ar_ready = 1;
      #1 chk("R1 rd addr", m_ar_addr, 64'(32'h40 + 8 * i));
      @(negedge clk);
    end
    m_ar_ready = 0;
    #1 chk("R1 rd no extra", m_ar_valid, 0);
    for (int i = 0; i < 3; i++) begin
      m_r_valid = 1; m_r_data = 32'hD0 + i; m_r_resp = (i == 0) ? 2'd2 : 2'd0;
      s_r_ready = (i != 1);
      #1;
      if (i == 1) begin
        chk("R10 r stall lite", m_r_ready, 0);
        @(negedge clk);
        #1 chk("R10 r still valid", s_r_valid, 1);
        s_r_ready = 1;
        #1;
      end
      chk("R7 r valid", s_r_valid, 1);
      chk("R7 r id", s_r_id, 3);
      chk("R7 r data", s_r_data, 64'(32'hD0 + i));
      chk("R7 r resp", s_r_resp, (i == 0) ? 2 : 0);
      chk("R7 r last", s_r_last, (i == 2));
      @(negedge clk);
    end
    m_r_valid = 0; s_r_ready = 0;
    #1 chk("R7 r idle", s_r_valid, 0);
  endtask

  // two single-beat writes fill the tracker
  task automatic t_overlap_full();
    m_aw_ready = 1;
    for (int b = 1; b <= 2; b++) begin
      @(negedge clk);
      s_aw_valid = 1; s_aw_id = IW'(b); s_aw_addr = 32'(b * 32'h100); s_aw_len = 0; s_aw_size = 3'd2;
      #1;
      for (int k = 0; k < 5 && !s_aw_ready; k++) begin
        @(negedge clk); #1;
      end
      @(negedge clk);
      s_aw_valid = 0;
    end
    @(negedge clk);
    s_aw_valid = 1; s_aw_id = 4'd9;
    #1 chk("R3 ready low full", s_aw_ready, 0);
    @(negedge clk);
    #1 chk("R3 still full", s_aw_ready, 0);
    s_aw_valid = 0; m_aw_ready = 0;
    m_b_valid = 1; m_b_resp = 2'd0; s_b_ready = 1;
    #1 chk("R8 first id", s_b_id, 1);
    @(negedge clk);
    #1 chk("R3 ready after free", s_aw_ready, 1);
    chk("R8 second id", s_b_id, 2);
    chk("R8 second valid", s_b_valid, 1);
    @(negedge clk);
    m_b_valid = 0; s_b_ready = 0;
    #1 chk("R5 all answered", s_b_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_write_burst();
    t_read_burst();
    t_overlap_full();
    repeat (2) @(negedge clk);
    report();
  end
endmodule